// File: doc/BRIEF.md
# PWM Carrier Chopper

This block superimposes a high-frequency carrier on a PWM level so that the result can drive a pulse transformer. While the incoming PWM level is high, the output is a train of carrier pulses. Each high phase opens with a wider start pulse, which gives the transformer enough energy to turn the switch on. After the start pulse, the periodic carrier keeps the switch on. When the PWM level is low, the output is low. When chopping is disabled, the PWM level passes straight through.

All timing is counted in clock cycles on a fixed base of sixteen clocks. Three settings shape the output:
- a carrier period selector;
- a carrier duty selector in eighths of the period;
- a start pulse width selector.

The block samples the three settings only while chopping is disabled. While chopping is enabled it keeps the captured values and ignores any change on the setting inputs.

Top module: `pwm_chopper`

## Requirements
- R1: After reset the captured settings are all zero, so with chopping enabled each PWM high phase gives a 16-clock start pulse followed by a constant low output. During reset the output is low while the PWM level is low.
- R2: While `chop_en_i` is 0, `chop_o` equals `pwm_i` in every cycle, and the start and carrier counters are held cleared.
- R3: With chopping enabled, a rising PWM level drives `chop_o` high in that same cycle. The output then stays high for (start + 1) × 16 clocks in total.
- R4: The carrier period is 16 × (freq + 1) clocks. The first period begins in the cycle right after the start pulse ends, and later periods follow back to back.
- R5: In each carrier period, `chop_o` is high for the first duty × 2 × (freq + 1) clocks and low for the rest of the period.
- R6: A duty value of 0 produces no carrier pulses: only the start pulse appears in each PWM high phase.
- R7: With chopping enabled, a low PWM level forces `chop_o` low in the same cycle, even in the middle of a start pulse. The next rising edge begins a full new start pulse.
- R8: The settings are captured at each clock edge at which `chop_en_i` is 0. Changes to `freq_sel_i`, `duty_sel_i` and `start_sel_i` while `chop_en_i` is 1 have no effect on the output timing.
- R9: Enabling chopping while the PWM level is already high counts as a rising edge: a start pulse begins in the cycle in which `chop_en_i` goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chop_en_i | input | 1 | Chopping enable; while 0 the settings are captured and the output follows `pwm_i` |
| freq_sel_i | input | 4 | Carrier period selector; the period is 16 × (value + 1) clocks |
| duty_sel_i | input | 3 | Carrier duty in eighths |
| start_sel_i | input | 4 | Start pulse width; the width is (value + 1) × 16 clocks |
| pwm_i | input | 1 | Raw PWM level |
| chop_o | output | 1 | Chopped output |

## Verification
Two functions can fall in the same cycle:
- the end of the start pulse and the start of the carrier, which share one handover cycle;
- a falling PWM level and an active start pulse or carrier.

The bench programs short, long and extreme period, duty and start settings. It compares every cycle of each PWM high phase against a profile computed from the formulas, so any off-by-one cycle at the handover from start pulse to carrier is reported. It also drops the PWM level in the middle of a start pulse. There it expects a low output in that same sample and a full new start pulse on the next rising edge. It also raises the enable while the PWM level is already high, and expects a start pulse in that same cycle.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int unsigned FREQ_W_D  = 4;
  localparam int unsigned DUTY_W_D  = 3;
  localparam int unsigned START_W_D = 4;
  localparam int unsigned BASE_W_D  = 4;  // log2 of the fixed divide-by-16 base
endpackage

// File: rtl/chop_cfg_lock.sv
module chop_cfg_lock #(
  parameter int unsigned FREQ_W  = chop_pkg::FREQ_W_D,
  parameter int unsigned DUTY_W  = chop_pkg::DUTY_W_D,
  parameter int unsigned START_W = chop_pkg::START_W_D
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [FREQ_W-1:0]  freq_i,
  input  logic [DUTY_W-1:0]  duty_i,
  input  logic [START_W-1:0] start_i,
  output logic [FREQ_W-1:0]  freq_o,
  output logic [DUTY_W-1:0]  duty_o,
  output logic [START_W-1:0] start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_o  <= '0;
      duty_o  <= '0;
      start_o <= '0;
    end else if (!en_i) begin
      freq_o  <= freq_i;
      duty_o  <= duty_i;
      start_o <= start_i;
    end
  end

  // R8: settings frozen while enabled
  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable({freq_o, duty_o, start_o}));
endmodule

// File: rtl/chop_start_timer.sv
module chop_start_timer #(
  parameter int unsigned START_W = chop_pkg::START_W_D,
  parameter int unsigned BASE_W  = chop_pkg::BASE_W_D,
  localparam int unsigned CNT_W  = START_W + BASE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               rise_i,
  input  logic [START_W-1:0] start_i,
  output logic               active_o,
  output logic               done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = {start_i, {BASE_W{1'b1}}};
  assign done_o = active_o && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (rise_i) begin
      // rise cycle itself is count 0, so the next cycle is count 1
      active_o <= 1'b1;
      cnt_q    <= CNT_W'(1);
    end else if (active_o) begin
      if (cnt_q == last) begin
        active_o <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R3: counter never runs past the programmed width
  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> cnt_q <= last);
  // R7: a low PWM level cuts the start pulse
  a_r7_cut_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !active_o);
endmodule

// File: rtl/chop_carrier_gen.sv
module chop_carrier_gen #(
  parameter int unsigned FREQ_W = chop_pkg::FREQ_W_D,
  parameter int unsigned DUTY_W = chop_pkg::DUTY_W_D,
  parameter int unsigned BASE_W = chop_pkg::BASE_W_D,
  localparam int unsigned CNT_W = FREQ_W + BASE_W,
  localparam int unsigned PRD_W = FREQ_W + DUTY_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              go_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              high_o
);
  logic              run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last;
  logic [FREQ_W:0]   freq_p1;
  logic [PRD_W-1:0]  prod;
  logic [CNT_W:0]    lim_wide;
  logic [CNT_W-1:0]  high_lim;

  assign last     = {freq_i, {BASE_W{1'b1}}};
  assign freq_p1  = {1'b0, freq_i} + {{FREQ_W{1'b0}}, 1'b1};
  assign prod     = {{(FREQ_W+1){1'b0}}, duty_i} * {{DUTY_W{1'b0}}, freq_p1};
  // duty/2^DUTY_W of a period of (freq+1)*2^BASE_W clocks
  assign lim_wide = (CNT_W+1)'(prod) << (BASE_W - DUTY_W);
  assign high_lim = lim_wide[CNT_W-1:0];
  assign high_o   = run_q && (cnt_q < high_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (go_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= (cnt_q == last) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // R4: period wraps at 16*(freq+1)
  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == last && !clr_i && !go_i) |=> (run_q && cnt_q == '0));
  // R6: zero duty gives no carrier
  a_r6_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == '0) |-> !high_o);
  a_r4_idle_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> cnt_q == '0);
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper #(
  parameter int unsigned FREQ_W  = chop_pkg::FREQ_W_D,
  parameter int unsigned DUTY_W  = chop_pkg::DUTY_W_D,
  parameter int unsigned START_W = chop_pkg::START_W_D,
  parameter int unsigned BASE_W  = chop_pkg::BASE_W_D
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               chop_en_i,
  input  logic [FREQ_W-1:0]  freq_sel_i,
  input  logic [DUTY_W-1:0]  duty_sel_i,
  input  logic [START_W-1:0] start_sel_i,
  input  logic               pwm_i,
  output logic               chop_o
);
  logic [FREQ_W-1:0]  freq_q;
  logic [DUTY_W-1:0]  duty_q;
  logic [START_W-1:0] start_q;
  logic pwm_q, rise, start_active, start_done, car_high;
  logic start_clr, car_clr, car_go;

  chop_cfg_lock #(.FREQ_W(FREQ_W), .DUTY_W(DUTY_W), .START_W(START_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (chop_en_i),
    .freq_i  (freq_sel_i),
    .duty_i  (duty_sel_i),
    .start_i (start_sel_i),
    .freq_o  (freq_q),
    .duty_o  (duty_q),
    .start_o (start_q)
  );

  // held low while disabled so enabling during a high phase reads as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pwm_q <= 1'b0;
    else if (!chop_en_i) pwm_q <= 1'b0;
    else                 pwm_q <= pwm_i;
  end

  assign rise      = chop_en_i && pwm_i && !pwm_q;
  assign start_clr = !chop_en_i || !pwm_i;
  assign car_clr   = start_clr || rise;
  assign car_go    = start_done;

  chop_start_timer #(.START_W(START_W), .BASE_W(BASE_W)) u_start (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_clr),
    .rise_i   (rise),
    .start_i  (start_q),
    .active_o (start_active),
    .done_o   (start_done)
  );

  chop_carrier_gen #(.FREQ_W(FREQ_W), .DUTY_W(DUTY_W), .BASE_W(BASE_W)) u_car (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (car_clr),
    .go_i   (car_go),
    .freq_i (freq_q),
    .duty_i (duty_q),
    .high_o (car_high)
  );

  assign chop_o = chop_en_i ? (pwm_i && (rise || start_active || car_high)) : pwm_i;

  // R9/R3: an enabled rising level is visible in the same cycle
  a_r3_rise_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chop_en_i && $rose(pwm_i)) |-> chop_o);
  // R2: counters stay cleared while disabled
  a_r2_held_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chop_en_i |=> (!start_active && !car_high));
endmodule

// File: tb/tb_pwm_chopper.sv
`timescale 1ns/1ps
module tb_pwm_chopper;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic chop_en_i = 1'b0;
  logic [3:0] freq_sel_i = '0;
  logic [2:0] duty_sel_i = '0;
  logic [3:0] start_sel_i = '0;
  logic pwm_i = 1'b0;
  logic chop_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pwm_chopper dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .chop_en_i(chop_en_i),
    .freq_sel_i(freq_sel_i), .duty_sel_i(duty_sel_i), .start_sel_i(start_sel_i),
    .pwm_i(pwm_i), .chop_o(chop_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_out(int k, int l, int p, int h);
    if (k < l) return 1'b1;
    return ((k - l) % p) < h;
  endfunction

  // disable, load settings, enable; leaves pwm low, just after a falling edge
  task automatic setup(input int f, input int d, input int s);
    @(negedge clk_i); #1;
    chop_en_i = 1'b0; pwm_i = 1'b0;
    freq_sel_i = 4'(f); duty_sel_i = 3'(d); start_sel_i = 4'(s);
    @(negedge clk_i); @(negedge clk_i); #1;
    chop_en_i = 1'b1;
    @(negedge clk_i); #1;
  endtask

  // raise pwm (and enable) and compare n cycles against the formula profile
  task automatic profile(input int f, input int d, input int s, input int n, input string req);
    int l, p, h, bad_k, bad_a, bad_e;
    bit ok;
    l = (s + 1) * 16; p = 16 * (f + 1); h = d * 2 * (f + 1);
    ok = 1'b1; bad_k = 0; bad_a = 0; bad_e = 0;
    pwm_i = 1'b1; chop_en_i = 1'b1;
    #1;
    for (int k = 0; k < n; k++) begin
      if (k > 0) begin @(negedge clk_i); #1; end
      if (ok && chop_o !== exp_out(k, l, p, h)) begin
        ok = 1'b0; bad_k = k; bad_a = int'(chop_o); bad_e = int'(exp_out(k, l, p, h));
      end
    end
    if (!ok) $display("  mismatch at cycle %0d of %s", bad_k, req);
    chk(ok, req, bad_a, bad_e);
  endtask

  task automatic drop_pwm(input string req);
    pwm_i = 1'b0; #1;
    chk(chop_o == 1'b0, req, int'(chop_o), 0);
    @(negedge clk_i); @(negedge clk_i); #1;
  endtask

  task automatic t_reset;
    chop_en_i = 1'b1; freq_sel_i = 4'd5; duty_sel_i = 3'd3; start_sel_i = 4'd2;
    #10;
    chk(chop_o == 1'b0, "R1 low in reset", int'(chop_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); #1;
    profile(0, 0, 0, 80, "R1 reset settings");
    drop_pwm("R1 drop");
  endtask

  task automatic t_bypass;
    bit ok = 1'b1;
    int a = 0, e = 0;
    setup(3, 4, 2);
    chop_en_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i); pwm_i = (i % 7) < 4; #1;
      if (ok && chop_o !== pwm_i) begin ok = 1'b0; a = int'(chop_o); e = int'(pwm_i); end
    end
    chk(ok, "R2 bypass", a, e);
    pwm_i = 1'b0;
  endtask

  task automatic t_start;
    setup(0, 4, 5);
    profile(0, 4, 5, 96 + 40, "R3 start width");
    drop_pwm("R3 drop");
    setup(1, 2, 15);
    profile(1, 2, 15, 256 + 64, "R3 max start width");
    drop_pwm("R3 drop max");
  endtask

  task automatic t_carrier;
    setup(3, 3, 1);
    profile(3, 3, 1, 32 + 3 * 64, "R4 R5 period 64 duty 3");
    drop_pwm("R5 drop a");
    setup(15, 7, 0);
    profile(15, 7, 0, 16 + 2 * 256, "R4 R5 period 256 duty 7");
    drop_pwm("R5 drop b");
    setup(0, 1, 2);
    profile(0, 1, 2, 48 + 5 * 16, "R4 R5 period 16 duty 1");
    drop_pwm("R5 drop c");
  endtask

  task automatic t_zero;
    setup(2, 0, 3);
    profile(2, 0, 3, 64 + 3 * 48, "R6 zero duty");
    drop_pwm("R6 drop");
  endtask

  task automatic t_cut;
    setup(1, 5, 7);
    profile(1, 5, 7, 20, "R7 before cut");
    pwm_i = 1'b0; #1;
    chk(chop_o == 1'b0, "R7 low same cycle", int'(chop_o), 0);
    @(negedge clk_i); #1;
    chk(chop_o == 1'b0, "R7 stays low", int'(chop_o), 0);
    @(negedge clk_i); #1;
    profile(1, 5, 7, 128 + 2 * 32, "R7 fresh start");
    drop_pwm("R7 drop");
  endtask

  task automatic t_lock;
    setup(1, 2, 1);
    freq_sel_i = 4'd9; duty_sel_i = 3'd6; start_sel_i = 4'd8;
    @(negedge clk_i); #1;
    profile(1, 2, 1, 32 + 3 * 32, "R8 changes ignored");
    drop_pwm("R8 drop");
    setup(9, 6, 8);
    profile(9, 6, 8, 144 + 2 * 160, "R8 recaptured");
    drop_pwm("R8 drop 2");
  endtask

  task automatic t_enable_high;
    setup(2, 3, 0);
    chop_en_i = 1'b0; pwm_i = 1'b1; #1;
    chk(chop_o == 1'b1, "R9 bypass high", int'(chop_o), 1);
    @(negedge clk_i); @(negedge clk_i); #1;
    profile(2, 3, 0, 16 + 3 * 48, "R9 enable while high");
    drop_pwm("R9 drop");
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_start();
    t_carrier();
    t_zero();
    t_cut();
    t_lock();
    t_enable_high();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule